// File: doc/BRIEF.md
# Address-and-Timer Fault Trigger Unit

This block sits on a processor's memory bus and corrupts the data word of one chosen transaction so that a system's error-detection logic can be exercised. Each bus cycle it sees an address, a transaction kind, a data word and the value of a free-running cycle counter. A set of configuration inputs chooses the trigger conditions and how they combine. The conditions are an instruction fetch from a set address, an operand load from it, an operand store to it, or a cycle count that has reached a threshold. When the combined condition holds on a valid transaction, the word is rewritten in the same cycle. The change follows a per-bit mask and one of four bit operations.

By default the unit fires once, then holds a sticky done flag and leaves all later traffic untouched until the flag is cleared. A repeat setting makes it fire on every qualifying transaction instead. Because triggering depends only on the configuration and the bus contents, the same configuration always corrupts the same transaction.

Top module: `fault_trigger_unit`

## Requirements
- R1: With fetch triggering enabled (cfg_enable bit 0), a valid transaction of kind 00 (fetch) whose address equals cfg_addr triggers an injection in that same cycle.
- R2: Load triggering (cfg_enable bit 1, kind 01) and store triggering (cfg_enable bit 2, kind 10) are enabled independently. A matching address of a kind whose trigger is disabled does not fire, and kind 11 never matches an address trigger.
- R3: With time triggering enabled (cfg_enable bit 3), the time condition holds whenever cycle_count is greater than or equal to cfg_time_limit. Any valid transaction in that window can fire.
- R4: cfg_combine 00 fires when any enabled condition holds. 01 fires only when every enabled condition holds and at least one is enabled. 10 and 11 never fire.
- R5: During an injection, only bits whose cfg_mask bit is 1 may differ between data_out and data_in.
- R6: cfg_op sets the operation on masked bits: 00 clears them, 01 sets them, 10 inverts them, 11 bridges them.
- R7: Bridging sets masked bit i to data_in bit i-1, and masked bit 0 takes the top bit of data_in.
- R8: When no injection occurs, data_out equals data_in in the same cycle and inject is 0.
- R9: In one-shot mode (cfg_repeat 0), an injection sets done_flag at the next clock edge, and no injection happens while done_flag is 1. Raising done_clear without an injection clears done_flag at the next edge. An injection in the same cycle takes priority over the clear.
- R10: With cfg_repeat 1, every qualifying transaction is injected regardless of done_flag.
- R11: After a synchronous reset, done_flag is 0.
- R12: The same configuration and the same transaction always produce the same data_out and inject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Transaction present this cycle |
| bus_addr | input | ADDR_W | Transaction address |
| bus_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 other |
| data_in | input | DATA_W | Data word from the bus |
| cycle_count | input | TIME_W | Free-running cycle counter |
| cfg_addr | input | ADDR_W | Address to match |
| cfg_enable | input | 4 | Trigger enables: bit0 fetch, bit1 load, bit2 store, bit3 time |
| cfg_time_limit | input | TIME_W | Cycle threshold for the time trigger |
| cfg_combine | input | 2 | 00 any, 01 all, others off |
| cfg_mask | input | DATA_W | Bits to corrupt |
| cfg_op | input | 2 | 00 clear, 01 set, 10 invert, 11 bridge |
| cfg_repeat | input | 1 | Fire on every match instead of once |
| done_clear | input | 1 | Clear the sticky done flag |
| data_out | output | DATA_W | Possibly corrupted data word |
| inject | output | 1 | High in the cycle a word is corrupted |
| done_flag | output | 1 | Sticky flag set by an injection |

## Verification
Directed cases isolate each trigger source in turn: a fetch hit, a store hit with loads disabled, and the catch-all kind. They also show that the threshold is inclusive, that the all-of mode needs every enabled source, and that the reserved combine codes are off. Single-bit masks at the low and high ends of the word distinguish a correct bridge wrap from a shift that drops or misroutes the top bit. Random traffic then mixes addresses near and equal to the match address, every kind, every operation, random masks and sporadic clears under changing configurations. This separates one-shot from repeat behaviour and catches a wrong priority between clear and a fresh injection.

// File: rtl/ftu_pkg.sv
package ftu_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_LOAD  = 2'b01,
    KIND_STORE = 2'b10,
    KIND_OTHER = 2'b11
  } bus_kind_e;

  typedef enum logic [1:0] {
    OP_CLEAR  = 2'b00,
    OP_SET    = 2'b01,
    OP_INVERT = 2'b10,
    OP_BRIDGE = 2'b11
  } bit_op_e;

  typedef enum logic [1:0] {
    COMB_ANY = 2'b00,
    COMB_ALL = 2'b01
  } comb_e;

  localparam int N_SRC = 4;
endpackage

// File: rtl/ftu_trigger.sv
module ftu_trigger
  import ftu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TIME_W = 32
) (
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_kind,
  input  logic [TIME_W-1:0] cycle_count,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [N_SRC-1:0]  cfg_enable,
  input  logic [TIME_W-1:0] cfg_time_limit,
  input  logic [1:0]        cfg_combine,
  output logic              hit
);
  logic              addr_eq;
  logic [N_SRC-1:0]  cond;
  logic              any_hit, all_hit;

  assign addr_eq = bus_valid && (bus_addr == cfg_addr);

  always_comb begin
    cond[0] = addr_eq && (bus_kind == KIND_FETCH);
    cond[1] = addr_eq && (bus_kind == KIND_LOAD);
    cond[2] = addr_eq && (bus_kind == KIND_STORE);
    cond[3] = (cycle_count >= cfg_time_limit);
  end

  assign any_hit = |(cond & cfg_enable);
  assign all_hit = (|cfg_enable) && (&(cond | ~cfg_enable));

  always_comb begin
    case (cfg_combine)
      COMB_ANY: hit = bus_valid && any_hit;
      COMB_ALL: hit = bus_valid && all_hit;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ftu_corrupt.sv
module ftu_corrupt
  import ftu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] mask,
  input  logic [1:0]        op,
  output logic [DATA_W-1:0] data_out
);
  logic [DATA_W-1:0] neigh;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == 0) begin : g_wrap
      assign neigh[i] = data_in[DATA_W-1];
    end else begin : g_lower
      assign neigh[i] = data_in[i-1];
    end

    always_comb begin
      if (!mask[i]) begin
        data_out[i] = data_in[i];
      end else begin
        case (op)
          OP_CLEAR:  data_out[i] = 1'b0;
          OP_SET:    data_out[i] = 1'b1;
          OP_INVERT: data_out[i] = ~data_in[i];
          default:   data_out[i] = neigh[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/fault_trigger_unit.sv
module fault_trigger_unit
  import ftu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_kind,
  input  logic [DATA_W-1:0] data_in,
  input  logic [TIME_W-1:0] cycle_count,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_enable,
  input  logic [TIME_W-1:0] cfg_time_limit,
  input  logic [1:0]        cfg_combine,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic [1:0]        cfg_op,
  input  logic              cfg_repeat,
  input  logic              done_clear,
  output logic [DATA_W-1:0] data_out,
  output logic              inject,
  output logic              done_flag
);
  logic              hit;
  logic              armed;
  logic [DATA_W-1:0] eff_mask;

  ftu_trigger #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_trig (
    .bus_valid      (bus_valid),
    .bus_addr       (bus_addr),
    .bus_kind       (bus_kind),
    .cycle_count    (cycle_count),
    .cfg_addr       (cfg_addr),
    .cfg_enable     (cfg_enable),
    .cfg_time_limit (cfg_time_limit),
    .cfg_combine    (cfg_combine),
    .hit            (hit)
  );

  assign armed    = !done_flag || cfg_repeat;
  assign inject   = hit && armed;
  assign eff_mask = inject ? cfg_mask : '0;

  ftu_corrupt #(.DATA_W(DATA_W)) u_corrupt (
    .data_in  (data_in),
    .mask     (eff_mask),
    .op       (cfg_op),
    .data_out (data_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_flag <= 1'b0;
    end else if (inject) begin
      done_flag <= 1'b1;
    end else if (done_clear) begin
      done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ftu_chk.sv
module ftu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              inject,
  input logic              done_flag,
  input logic              done_clear,
  input logic              cfg_repeat,
  input logic [1:0]        cfg_combine,
  input logic [DATA_W-1:0] cfg_mask,
  input logic [DATA_W-1:0] data_in,
  input logic [DATA_W-1:0] data_out
);
  // R9
  done_sets_chk: assert property (@(posedge clk) disable iff (rst)
    inject |=> done_flag);

  // R9
  one_shot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !cfg_repeat) |-> !inject);

  // R9
  clear_works_chk: assert property (@(posedge clk) disable iff (rst)
    (done_clear && !inject) |=> !done_flag);

  // R8
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    !inject |-> (data_out == data_in));

  // R5
  mask_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inject |-> (((data_out ^ data_in) & ~cfg_mask) == '0));

  // R4
  combine_off_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_combine[1] |-> !inject);
endmodule

bind fault_trigger_unit ftu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inject     (inject),
  .done_flag  (done_flag),
  .done_clear (done_clear),
  .cfg_repeat (cfg_repeat),
  .cfg_combine(cfg_combine),
  .cfg_mask   (cfg_mask),
  .data_in    (data_in),
  .data_out   (data_out)
);

// File: tb/fault_trigger_unit_test.sv
`timescale 1ns/1ps
module fault_trigger_unit_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_kind = 2'b11;
  logic [DW-1:0] data_in = '0;
  logic [TW-1:0] tick = '0;
  logic [AW-1:0] cfg_addr = 32'h0000_1000;
  logic [3:0]    cfg_enable = '0;
  logic [TW-1:0] cfg_time_limit = '1;
  logic [1:0]    cfg_combine = 2'b00;
  logic [DW-1:0] cfg_mask = '0;
  logic [1:0]    cfg_op = 2'b00;
  logic          cfg_repeat = 1'b0;
  logic          done_clear = 1'b0;
  logic [DW-1:0] data_out;
  logic          inject;
  logic          done_flag;

  int checks = 0;
  int errors = 0;
  logic m_done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tick <= '0;
    else     tick <= tick + 1'b1;
  end

  fault_trigger_unit #(.ADDR_W(AW), .DATA_W(DW), .TIME_W(TW)) uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_kind(bus_kind), .data_in(data_in), .cycle_count(tick),
    .cfg_addr(cfg_addr), .cfg_enable(cfg_enable),
    .cfg_time_limit(cfg_time_limit), .cfg_combine(cfg_combine),
    .cfg_mask(cfg_mask), .cfg_op(cfg_op), .cfg_repeat(cfg_repeat),
    .done_clear(done_clear), .data_out(data_out), .inject(inject),
    .done_flag(done_flag)
  );

  function automatic logic ref_trigger();
    logic am, cf, cl, cs, ct, anyc, allc;
    am = bus_valid && (bus_addr == cfg_addr);
    cf = am && bus_kind == 2'b00;
    cl = am && bus_kind == 2'b01;
    cs = am && bus_kind == 2'b10;
    ct = tick >= cfg_time_limit;
    anyc = (cfg_enable[0] && cf) || (cfg_enable[1] && cl) ||
           (cfg_enable[2] && cs) || (cfg_enable[3] && ct);
    allc = (cfg_enable != 0) && (!cfg_enable[0] || cf) && (!cfg_enable[1] || cl) &&
           (!cfg_enable[2] || cs) && (!cfg_enable[3] || ct);
    if (!bus_valid) return 1'b0;
    if (cfg_combine == 2'b00) return anyc;
    if (cfg_combine == 2'b01) return allc;
    return 1'b0;
  endfunction

  function automatic logic [DW-1:0] ref_corrupt(logic [DW-1:0] d, logic [DW-1:0] m, logic [1:0] op);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) begin
      if (!m[i]) r[i] = d[i];
      else if (op == 2'b00) r[i] = 1'b0;
      else if (op == 2'b01) r[i] = 1'b1;
      else if (op == 2'b10) r[i] = !d[i];
      else r[i] = d[(i + DW - 1) % DW];
    end
    return r;
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One bus cycle: drive after the falling edge, check combinational
  // outputs, then check the registered flag after the rising edge.
  task automatic drive(input logic v, input logic [AW-1:0] a, input logic [1:0] k,
                       input logic [DW-1:0] d, input logic clr, input string req);
    logic fire;
    logic [DW-1:0] expd;
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_kind = k; data_in = d; done_clear = clr;
    #1;
    fire = ref_trigger() && (!m_done || cfg_repeat);
    expd = fire ? ref_corrupt(d, cfg_mask, cfg_op) : d;
    check(DW'(inject), DW'(fire), req);
    check(data_out, expd, req);
    @(posedge clk);
    if (fire) m_done = 1'b1;
    else if (clr) m_done = 1'b0;
    #1;
    check(DW'(done_flag), DW'(m_done), req);
    done_clear = 1'b0;
  endtask

  task automatic clear_done();
    drive(1'b0, '0, 2'b11, '0, 1'b1, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [DW-1:0] first;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R11: reset state
    check(DW'(done_flag), 0, "R11");
    check(DW'(inject), 0, "R11");

    // R1: fetch hit, invert
    cfg_enable = 4'b0001; cfg_mask = 32'h0000_00FF; cfg_op = 2'b10;
    drive(1, cfg_addr + 4, 2'b00, 32'h1234_5678, 0, "R8");
    drive(1, cfg_addr, 2'b00, 32'h1234_5678, 0, "R1");
    check(DW'(m_done), 1, "R1");
    // R9: ignored while done
    drive(1, cfg_addr, 2'b00, 32'hAAAA_5555, 0, "R9");
    // R9: injection beats clear in the same cycle
    clear_done();
    drive(1, cfg_addr, 2'b00, 32'h0, 1, "R9");
    clear_done();

    // R2: store enabled, load disabled; kind 11 never
    cfg_enable = 4'b0100; cfg_op = 2'b01;
    drive(1, cfg_addr, 2'b01, 32'h0, 0, "R2");
    drive(1, cfg_addr, 2'b11, 32'h0, 0, "R2");
    drive(1, cfg_addr, 2'b10, 32'h0, 0, "R2");
    clear_done();
    cfg_enable = 4'b0010; cfg_op = 2'b00; cfg_mask = 32'hFFFF_0000;
    drive(1, cfg_addr, 2'b01, 32'hFFFF_FFFF, 0, "R6");
    clear_done();

    // R3: time threshold inclusive
    cfg_enable = 4'b1000; cfg_time_limit = tick + 4;
    drive(1, 32'h5, 2'b11, 32'h0F0F, 0, "R3");
    drive(1, 32'h5, 2'b11, 32'h0F0F, 0, "R3");
    drive(1, 32'h5, 2'b11, 32'h0F0F, 0, "R3");
    drive(1, 32'h5, 2'b11, 32'h0F0F, 0, "R3");
    clear_done();

    // R4: all-of mode, then reserved codes
    cfg_enable = 4'b1001; cfg_combine = 2'b01; cfg_time_limit = tick + 3;
    drive(1, cfg_addr, 2'b00, 32'h1, 0, "R4");
    drive(1, cfg_addr, 2'b00, 32'h1, 0, "R4");
    drive(1, cfg_addr, 2'b00, 32'h1, 0, "R4");
    clear_done();
    cfg_combine = 2'b10;
    drive(1, cfg_addr, 2'b00, 32'h1, 0, "R4");
    cfg_combine = 2'b11;
    drive(1, cfg_addr, 2'b00, 32'h1, 0, "R4");
    cfg_combine = 2'b01; cfg_enable = 4'b0000;
    drive(1, cfg_addr, 2'b00, 32'h1, 0, "R4");
    cfg_combine = 2'b00;

    // R7: bridging, low bit and wrap
    cfg_enable = 4'b0001; cfg_op = 2'b11; cfg_repeat = 1'b1;
    cfg_mask = 32'h0000_0002;
    drive(1, cfg_addr, 2'b00, 32'h0000_0001, 0, "R7");
    check(data_out, 32'h0000_0003, "R7");
    cfg_mask = 32'h0000_0001;
    drive(1, cfg_addr, 2'b00, 32'h8000_0000, 0, "R7");
    check(data_out, 32'h8000_0001, "R7");

    // R10 and R12: repeat mode, same transaction twice
    cfg_mask = 32'h00F0_0F00; cfg_op = 2'b10;
    drive(1, cfg_addr, 2'b00, 32'hCAFE_BABE, 0, "R10");
    first = data_out;
    drive(1, cfg_addr, 2'b00, 32'hCAFE_BABE, 0, "R12");
    check(data_out, first, "R12");
    check(data_out, 32'hCAFE_BABE ^ 32'h00F0_0F00, "R12");
    cfg_repeat = 1'b0;
    clear_done();

    // Random traffic, R5 R6 R8 R9 R10
    for (int it = 0; it < 1500; it++) begin
      logic [1:0] pick;
      logic [AW-1:0] a;
      if (it % 25 == 0) begin
        cfg_enable = 4'($urandom);
        cfg_combine = ($urandom % 4 == 0) ? 2'($urandom) : 2'($urandom % 2);
        cfg_mask = $urandom;
        cfg_op = 2'($urandom);
        cfg_repeat = ($urandom % 3 == 0);
        cfg_time_limit = tick + ($urandom % 60);
      end
      pick = 2'($urandom);
      a = (pick == 0) ? cfg_addr + 4 : (pick == 1) ? $urandom : cfg_addr;
      drive($urandom % 8 != 0, a, 2'($urandom), $urandom, $urandom % 8 == 0,
            cfg_repeat ? "R10" : "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule